// File: doc/BRIEF.md
# POST Checkpoint Beep-Code Sequencer

This block watches the self-test progress bytes that boot firmware writes to a debug port. Every byte written is held in a register that other logic can read. A few of the bytes mark failures that must be audible. For these bytes the block drives a speaker gate with a pattern of four beep groups. The pattern is built from the byte's four 2-bit fields, starting with the most significant field. Each field value is raised by one, so every group has one to four beeps.

A beep is a fixed number of cycles with the gate high, followed by a short low time. A longer silence separates one group from the next, and a still longer pause ends each full pattern. The two memory-failure bytes are halt points: their pattern repeats until reset. A pulse on the fatal input has the same effect on the pattern in progress. A byte written while a pattern is playing never cuts that pattern short. The most recent audible byte written during playback is played once the current pattern ends.

Top module: `beep_code_seq`

## Requirements
- R1: `cp_latched` is 0x00 after reset, takes `wr_data` on every cycle where `wr_en` is high (whether or not the byte beeps), and holds its value otherwise.
- R2: Only bytes 0x16, 0x20, 0x22, 0x28 and 0x2C start a pattern. Writing any other byte while idle leaves `spk_gate` and `busy` low.
- R3: A pattern has four groups. Group g (g = 0 first) sounds (bits [7-2g : 6-2g] of the byte) + 1 beeps. For example, 0x16 gives 1-2-2-3, 0x20 gives 1-3-1-1 and 0x2C gives 1-3-4-1.
- R4: Each beep holds `spk_gate` high for exactly ON_CYC cycles. Between two beeps of the same group, the gate is low for exactly OFF_CYC cycles.
- R5: Between the last beep of one group and the first beep of the next, the gate is low for OFF_CYC+GAP_CYC cycles. After the last beep of the fourth group, the gate is low for OFF_CYC+PAUSE_CYC cycles while `busy` stays high.
- R6: `busy` rises in the same cycle as the first beep and falls only when the final pause ends. `spk_gate` is never high while `busy` is low.
- R7: A write during playback does not disturb the pattern in progress. If an audible byte was written during playback, the latest such byte starts as soon as the pause ends. This also applies to a write that arrives in the last cycle of the pause.
- R8: After byte 0x28 or 0x2C starts playing, the pattern repeats back to back until reset. Later writes are latched but never played.
- R9: A pulse on `fatal_in` during playback makes the current pattern repeat until reset. A pulse while idle starts a repeating pattern if the latched byte is audible; if the latched byte is not audible, no pattern starts.
- R10: While `rst_n` is low, `spk_gate` and `busy` are low and `cp_latched` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously and is released synchronously inside the block. |
| wr_en | input | 1 | Write strobe for a checkpoint byte |
| wr_data | input | 8 | Checkpoint byte |
| fatal_in | input | 1 | Forces the pattern to repeat until reset |
| spk_gate | output | 1 | Speaker enable |
| busy | output | 1 | High while a pattern, including its final pause, is in progress |
| cp_latched | output | 8 | Most recently written checkpoint byte |

## Verification
The sharpest collision is between the end of a pattern's final pause and a new audible write in that same cycle. The sequencer must decide in one cycle to start the new byte, not fall back to idle and lose it. The bench provokes this by counting the low cycles after the last beep and raising the strobe exactly in the last pause cycle. It then judges the result by requiring the new byte's first beep to follow at once, with no idle cycle in between. A second overlap, a fatal pulse or halt byte against a pending write, is judged by checking that the halted pattern keeps repeating while `cp_latched` shows the newer byte.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int CP_W   = 8;
  localparam int FLD_W  = 2;
  localparam int GRP_N  = CP_W / FLD_W;
  localparam int GRP_W  = $clog2(GRP_N);
  localparam int BEAT_W = FLD_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON,
    ST_OFF,
    ST_GAP,
    ST_PAUSE
  } bcs_state_e;

  // Checkpoints that are announced on the speaker.
  function automatic logic cp_audible(input logic [CP_W-1:0] cp);
    case (cp)
      8'h16, 8'h20, 8'h22, 8'h28, 8'h2C: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // Checkpoints after which firmware never continues.
  function automatic logic cp_halting(input logic [CP_W-1:0] cp);
    return (cp == 8'h28) || (cp == 8'h2C);
  endfunction
endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/bcs_capture.sv
module bcs_capture
  import bcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CP_W-1:0] wr_data,
  output logic [CP_W-1:0] cp_q,
  output logic            wr_go,
  output logic            held_go
);
  logic [CP_W-1:0] cp_d;
  logic            cp_en;

  always_comb begin
    cp_en = wr_en;
    cp_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cp_q <= '0;
    else if (cp_en) cp_q <= cp_d;
  end

  assign wr_go   = wr_en & cp_audible(wr_data);
  assign held_go = cp_audible(cp_q);
endmodule

// File: rtl/bcs_timer.sv
module bcs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int ON_CYC    = 4,
  parameter int OFF_CYC   = 2,
  parameter int GAP_CYC   = 6,
  parameter int PAUSE_CYC = 10,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [CP_W-1:0]  wr_data,
  input  logic [CP_W-1:0]  cp_q,
  input  logic             held_go,
  input  logic             fatal_in,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             spk_gate,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ON_LD    = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] OFF_LD   = CNT_W'(OFF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] PAUSE_LD = CNT_W'(PAUSE_CYC - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GRP_N - 1);

  bcs_state_e        state_q, state_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CP_W-1:0]   play_q, play_d;
  logic [CP_W-1:0]   pcode_q, pcode_d;
  logic              pend_q, pend_d;
  logic              halt_q, halt_d;
  logic              start;
  logic              play_en, pcode_en;
  logic [BEAT_W-1:0] dig_arr [GRP_N];
  logic [BEAT_W-1:0] digit;

  // One-based digit of each group, most significant field first.
  for (genvar gi = 0; gi < GRP_N; gi++) begin : g_digit
    assign dig_arr[gi] = {1'b0, play_q[CP_W-1-FLD_W*gi -: FLD_W]} + BEAT_W'(1);
  end
  assign digit = dig_arr[grp_q];

  always_comb begin
    state_d  = state_q;
    grp_d    = grp_q;
    beat_d   = beat_q;
    play_d   = play_q;
    pcode_d  = pcode_q;
    pend_d   = pend_q;
    halt_d   = halt_q | fatal_in;
    tmr_load = 1'b0;
    tmr_val  = ON_LD;
    start    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (wr_go) begin
          start  = 1'b1;
          play_d = wr_data;
          halt_d = halt_d | cp_halting(wr_data);
        end else if (fatal_in && held_go) begin
          start  = 1'b1;
          play_d = cp_q;
        end
      end
      ST_ON: begin
        if (tmr_expired) begin
          state_d  = ST_OFF;
          tmr_load = 1'b1;
          tmr_val  = OFF_LD;
        end
      end
      ST_OFF: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (beat_q < digit) begin
            beat_d  = beat_q + 1'b1;
            state_d = ST_ON;
            tmr_val = ON_LD;
          end else if (grp_q != GRP_LAST) begin
            state_d = ST_GAP;
            tmr_val = GAP_LD;
          end else begin
            state_d = ST_PAUSE;
            tmr_val = PAUSE_LD;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          grp_d    = grp_q + 1'b1;
          beat_d   = BEAT_W'(1);
          state_d  = ST_ON;
          tmr_load = 1'b1;
          tmr_val  = ON_LD;
        end
      end
      ST_PAUSE: begin
        if (tmr_expired) begin
          if (halt_q || fatal_in) begin
            start = 1'b1;
          end else if (wr_go) begin
            start  = 1'b1;
            play_d = wr_data;
            halt_d = halt_d | cp_halting(wr_data);
            pend_d = 1'b0;
          end else if (pend_q) begin
            start  = 1'b1;
            play_d = pcode_q;
            halt_d = halt_d | cp_halting(pcode_q);
            pend_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_IDLE && wr_go && !start) begin
      pend_d  = 1'b1;
      pcode_d = wr_data;
    end
    if (start) begin
      state_d  = ST_ON;
      grp_d    = '0;
      beat_d   = BEAT_W'(1);
      tmr_load = 1'b1;
      tmr_val  = ON_LD;
    end
    play_en  = start;
    pcode_en = (pcode_d != pcode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      beat_q  <= '0;
      pend_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      beat_q  <= beat_d;
      pend_q  <= pend_d;
      halt_q  <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       play_q <= '0;
    else if (play_en) play_q <= play_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcode_q <= '0;
    else if (pcode_en) pcode_q <= pcode_d;
  end

  assign spk_gate = (state_q == ST_ON);
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/beep_code_seq.sv
module beep_code_seq
  import bcs_pkg::*;
#(
  parameter int ON_CYC    = 4,
  parameter int OFF_CYC   = 2,
  parameter int GAP_CYC   = 6,
  parameter int PAUSE_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fatal_in,
  output logic       spk_gate,
  output logic       busy,
  output logic [7:0] cp_latched
);
  localparam int MAX_A   = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int MAX_B   = (GAP_CYC > PAUSE_CYC) ? GAP_CYC : PAUSE_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             srst_n;
  logic             wr_go, held_go;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  bcs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bcs_capture u_cap (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cp_q    (cp_latched),
    .wr_go   (wr_go),
    .held_go (held_go)
  );

  bcs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  bcs_fsm #(
    .ON_CYC    (ON_CYC),
    .OFF_CYC   (OFF_CYC),
    .GAP_CYC   (GAP_CYC),
    .PAUSE_CYC (PAUSE_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_go       (wr_go),
    .wr_data     (wr_data),
    .cp_q        (cp_latched),
    .held_go     (held_go),
    .fatal_in    (fatal_in),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .spk_gate    (spk_gate),
    .busy        (busy)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int ON_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       fatal_in,
  input logic       spk_gate,
  input logic       busy,
  input logic [7:0] cp_latched
);
  logic [15:0] hi_q;
  logic        halt_arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_q <= '0;
    else if (spk_gate) hi_q <= hi_q + 16'd1;
    else               hi_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_arm_q <= 1'b0;
    else if (!busy && wr_en && cp_halting(wr_data)) halt_arm_q <= 1'b1;
  end

  // R1: every strobe is captured
  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cp_latched == $past(wr_data));

  // R1: no strobe, no change
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cp_latched));

  // R2: silent bytes do not start
  assert_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !cp_audible(wr_data) && !fatal_in) |=> !busy);

  // R4: a beep never exceeds its on-time
  assert_on_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spk_gate |-> hi_q < 16'(ON_CYC));

  // R4: a beep is never cut short
  assert_on_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spk_gate) |-> $past(hi_q) == 16'(ON_CYC - 1));

  // R6: gate only while busy
  assert_gate_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spk_gate |-> busy);

  // R8: a halt pattern never stops
  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_arm_q |-> busy);
endmodule

bind beep_code_seq bcs_checker #(.ON_CYC(ON_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .fatal_in   (fatal_in),
  .spk_gate   (spk_gate),
  .busy       (busy),
  .cp_latched (cp_latched)
);

// File: tb/beep_code_seq_tb.sv
module beep_code_seq_tb;
  localparam int ON    = 4;
  localparam int OFF   = 2;
  localparam int GAP   = 6;
  localparam int PAUSE = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       fatal_in;
  logic       spk_gate;
  logic       busy;
  logic [7:0] cp_latched;

  int checks;
  int errors;
  int cyc;

  beep_code_seq #(
    .ON_CYC(ON), .OFF_CYC(OFF), .GAP_CYC(GAP), .PAUSE_CYC(PAUSE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fatal_in(fatal_in), .spk_gate(spk_gate), .busy(busy),
    .cp_latched(cp_latched)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic pulse_fatal();
    @(negedge clk);
    fatal_in = 1'b1;
    @(negedge clk);
    fatal_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!spk_gate, "R10", "gate in reset", int'(spk_gate), 0);
    chk(!busy, "R10", "busy in reset", int'(busy), 0);
    chk(cp_latched == 8'h00, "R1", "latch in reset", int'(cp_latched), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Measures one whole pattern at the speaker gate (R3, R4, R5, R6).
  task automatic observe(input logic [7:0] code, input string req,
                         input bit inj, input logic [7:0] inj_d);
    int w;
    w = 0;
    while (!spk_gate && w < 400) begin
      @(negedge clk);
      w++;
    end
    chk(spk_gate, req, "pattern start", int'(spk_gate), 1);
    for (int g = 0; g < 4; g++) begin
      int d;
      d = int'(code[7-2*g -: 2]) + 1;
      for (int b = 1; b <= d; b++) begin
        int hi, lo, exp_lo;
        bit last;
        hi = 0;
        while (spk_gate && hi < 100) begin
          hi++;
          @(negedge clk);
        end
        chk(hi == ON, "R4", "beep on-time", hi, ON);
        last   = (g == 3) && (b == d);
        exp_lo = (b < d) ? OFF : ((g < 3) ? OFF + GAP : OFF + PAUSE);
        lo = 0;
        while (!spk_gate && busy && lo < 200) begin
          lo++;
          if (inj && last && lo == OFF + PAUSE) begin
            wr_en   = 1'b1;
            wr_data = inj_d;
          end
          @(negedge clk);
          if (inj) wr_en = 1'b0;
        end
        if (b < d) chk(lo == exp_lo, "R4", "in-group low", lo, exp_lo);
        else       chk(lo == exp_lo, "R5", "group/pause low", lo, exp_lo);
        if (b < d)
          chk(spk_gate, "R3", $sformatf("group %0d beep count", g), b, d);
        else if (!last)
          chk(lo == exp_lo, "R3", $sformatf("group %0d ends after %0d", g, d), b, d);
      end
    end
    if (!spk_gate) chk(!busy, "R6", "busy after pause", int'(busy), 0);
  endtask

  // {audible, byte}
  localparam logic [8:0] VEC [7] = '{
    {1'b1, 8'h16}, {1'b1, 8'h20}, {1'b0, 8'h4B}, {1'b1, 8'h22},
    {1'b0, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'h2D}
  };

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; fatal_in = 1'b0;
    do_reset();
    chk(!busy && !spk_gate, "R6", "idle after reset", int'(busy), 0);

    // Vector walk: R1, R2, R3
    for (int i = 0; i < 7; i++) begin
      do_write(VEC[i][7:0]);
      chk(cp_latched == VEC[i][7:0], "R1", "latched byte",
          int'(cp_latched), int'(VEC[i][7:0]));
      if (VEC[i][8]) begin
        chk(busy, "R6", "busy with first beep", int'(busy), 1);
        observe(VEC[i][7:0], "R3", 1'b0, 8'h00);
      end else begin
        int seen;
        seen = 0;
        repeat (30) begin
          @(negedge clk);
          if (busy || spk_gate) seen++;
        end
        chk(seen == 0, "R2", "silent byte", seen, 0);
      end
    end

    // R7: writes during playback wait; the latest audible one plays next
    do_write(8'h16);
    fork
      observe(8'h16, "R7", 1'b0, 8'h00);
      begin
        repeat (12) @(negedge clk);
        do_write(8'h22);
        do_write(8'h20);
        do_write(8'h4B);
      end
    join
    chk(spk_gate, "R7", "next pattern without idle", int'(spk_gate), 1);
    observe(8'h20, "R7", 1'b0, 8'h00);
    chk(cp_latched == 8'h4B, "R1", "latest latched", int'(cp_latched), 'h4B);

    // R7: write in the last pause cycle
    do_write(8'h20);
    observe(8'h20, "R7", 1'b1, 8'h22);
    chk(spk_gate, "R7", "collision start", int'(spk_gate), 1);
    observe(8'h22, "R7", 1'b0, 8'h00);

    // R8: halt byte 0x28 repeats; later writes latched only
    do_reset();
    do_write(8'h28);
    fork
      observe(8'h28, "R8", 1'b0, 8'h00);
      begin
        repeat (20) @(negedge clk);
        do_write(8'h16);
      end
    join
    chk(spk_gate, "R8", "repeat start", int'(spk_gate), 1);
    observe(8'h28, "R8", 1'b0, 8'h00);
    observe(8'h28, "R8", 1'b0, 8'h00);
    chk(cp_latched == 8'h16, "R8", "latched during halt", int'(cp_latched), 'h16);
    do_reset();
    chk(!busy, "R10", "halt cleared by reset", int'(busy), 0);

    // R8: halt byte 0x2C
    do_write(8'h2C);
    observe(8'h2C, "R8", 1'b0, 8'h00);
    chk(busy, "R8", "0x2C repeats", int'(busy), 1);
    observe(8'h2C, "R8", 1'b0, 8'h00);
    do_reset();

    // R9: fatal during playback
    do_write(8'h20);
    fork
      observe(8'h20, "R9", 1'b0, 8'h00);
      begin
        repeat (10) @(negedge clk);
        pulse_fatal();
      end
    join
    chk(spk_gate, "R9", "fatal repeat", int'(spk_gate), 1);
    observe(8'h20, "R9", 1'b0, 8'h00);
    do_reset();

    // R9: fatal while idle with a silent byte latched
    do_write(8'h4B);
    pulse_fatal();
    begin
      int seen;
      seen = 0;
      repeat (30) begin
        @(negedge clk);
        if (busy || spk_gate) seen++;
      end
      chk(seen == 0, "R9", "fatal on silent byte", seen, 0);
    end
    do_reset();

    // R9: fatal while idle with an audible byte latched
    do_write(8'h22);
    observe(8'h22, "R9", 1'b0, 8'h00);
    chk(!busy, "R9", "idle before fatal", int'(busy), 0);
    pulse_fatal();
    chk(spk_gate, "R9", "fatal start from idle", int'(spk_gate), 1);
    observe(8'h22, "R9", 1'b0, 8'h00);
    chk(busy, "R9", "fatal pattern repeats", int'(busy), 1);
    do_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule